// File: doc/BRIEF.md
# DRAM Power-Up and Idle Re-Initialization Sequencer

This block sits on the controller side of an asynchronous DRAM interface. It brings the memory into a usable state after power is applied. From reset it holds the row strobe and the column strobe high (inactive) for a start-up pause of at least 200 microseconds. It then issues a fixed number of row-only strobe cycles, and only after the last of these has finished precharging does it raise a ready flag for the normal access logic.

While ready, the sequencer watches an activity pulse from the access logic. If no pulse arrives for longer than the refresh interval, the memory must be treated as having sat without clocks. The sequencer then drops ready and runs the dummy-cycle train again before raising ready once more. The pause and the idle limit are set in microseconds and converted to clock counts, rounded up, from a clock-frequency parameter.

Top module: `dramInitSeq`

## Requirements
- R1: While `rstN` is low, `rasN` and `casN` are 1 and `ready` is 0.
- R2: The pause length is P = ceil(PAUSE_US * CLK_FREQ_HZ / 1e6) clocks. `rasN` stays 1 after reset release and first goes to 0 on exactly the P-th rising clock edge after release.
- R3: Pulses on `activity` while the pause or an initialization train is running have no effect: the pause length and the pulse widths are unchanged.
- R4: Each initialization cycle drives `rasN` to 0 for exactly RAS_LOW_CLKS clocks, followed by exactly RAS_HIGH_CLKS clocks of `rasN` at 1.
- R5: A train holds exactly INIT_CYCLES low pulses. `ready` goes to 1 on the edge that ends the precharge of the last pulse, and stays 0 throughout the train.
- R6: `casN` is 1 in every cycle.
- R7: While `ready` is 1, `rasN` stays 1. `ready` stays 1 as long as consecutive `activity` pulses, including the entry into ready, are at most I clocks apart, where I = ceil(REFRESH_US * CLK_FREQ_HZ / 1e6).
- R8: If I rising edges pass after the last `activity` pulse (or after entry into ready) with no new pulse, `ready` falls to 0 and `rasN` falls to 0 on that same edge. A full train per R4 and R5 follows, and then `ready` returns to 1.
- R9: `ready` is never 1 in a cycle where `rasN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| activity | input | 1 | One-clock pulse from the access logic marking DRAM use; clears the idle timer while ready |
| rasN | output | 1 | Row address strobe, active low |
| casN | output | 1 | Column address strobe, active low, held inactive |
| ready | output | 1 | High when the DRAM may be used by the access logic |

## Verification
The checker assumes that `activity` is a synchronous level sampled on rising edges and that reset is held across at least two edges. Its width and mutual-exclusion properties then depend only on the sequencer's own outputs. The stimulus drives all inputs on falling edges, holds reset for several cycles, and draws activity gaps from 1 to I clocks while ready, so that the idle limit is hit only when the bench deliberately stops pulsing. A clock frequency that is not a whole number of megahertz is used, so that the rounding of both P and I is exercised.

// File: rtl/dramInitPkg.sv
package dramInitPkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_READY = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic incTimer;
    logic clrPhase;
    logic incPhase;
    logic clrCycle;
    logic incCycle;
  } seqStrobes_t;

endpackage

// File: rtl/dramInitDatapath.sv
module dramInitDatapath
  import dramInitPkg::*;
#(
  parameter int PAUSE_CLKS    = 20000,
  parameter int IDLE_CLKS     = 1600000,
  parameter int INIT_CYCLES   = 8,
  parameter int RAS_LOW_CLKS  = 4,
  parameter int RAS_HIGH_CLKS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strobes,
  output logic        pauseDone,
  output logic        idleHit,
  output logic        lowDone,
  output logic        highDone,
  output logic        lastCycle
);

  localparam int TIMER_MAX = (PAUSE_CLKS > IDLE_CLKS) ? PAUSE_CLKS : IDLE_CLKS;
  localparam int TIMER_W   = $clog2(TIMER_MAX + 1);
  localparam int PHASE_MAX = (RAS_LOW_CLKS > RAS_HIGH_CLKS) ? RAS_LOW_CLKS : RAS_HIGH_CLKS;
  localparam int PHASE_W   = $clog2(PHASE_MAX + 1);
  localparam int CYCLE_W   = $clog2(INIT_CYCLES + 1);

  localparam logic [TIMER_W-1:0] PAUSE_LAST = TIMER_W'(PAUSE_CLKS - 1);
  localparam logic [TIMER_W-1:0] IDLE_LAST  = TIMER_W'(IDLE_CLKS - 1);
  localparam logic [PHASE_W-1:0] LOW_LAST   = PHASE_W'(RAS_LOW_CLKS - 1);
  localparam logic [PHASE_W-1:0] HIGH_LAST  = PHASE_W'(RAS_HIGH_CLKS - 1);
  localparam logic [CYCLE_W-1:0] CYCLE_LAST = CYCLE_W'(INIT_CYCLES - 1);

  logic [TIMER_W-1:0] timerQ;
  logic [PHASE_W-1:0] phaseQ;
  logic [CYCLE_W-1:0] cycleQ;

  // shared timer: pause length, then idle interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timerQ <= '0;
    else if (strobes.clrTimer) timerQ <= '0;
    else if (strobes.incTimer) timerQ <= timerQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseQ <= '0;
    else if (strobes.clrPhase) phaseQ <= '0;
    else if (strobes.incPhase) phaseQ <= phaseQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cycleQ <= '0;
    else if (strobes.clrCycle) cycleQ <= '0;
    else if (strobes.incCycle) cycleQ <= cycleQ + 1'b1;
  end

  assign pauseDone = (timerQ == PAUSE_LAST);
  assign idleHit   = (timerQ == IDLE_LAST);
  assign lowDone   = (phaseQ == LOW_LAST);
  assign highDone  = (phaseQ == HIGH_LAST);
  assign lastCycle = (cycleQ == CYCLE_LAST);

endmodule

// File: rtl/dramInitControl.sv
module dramInitControl
  import dramInitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        activity,
  input  logic        pauseDone,
  input  logic        idleHit,
  input  logic        lowDone,
  input  logic        highDone,
  input  logic        lastCycle,
  output seqStrobes_t strobes,
  output logic        rasN,
  output logic        ready
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_PAUSE: begin
        strobes.incTimer = 1'b1;
        if (pauseDone) begin
          stateD           = ST_LOW;
          strobes.clrPhase = 1'b1;
          strobes.clrCycle = 1'b1;
        end
      end
      ST_LOW: begin
        strobes.incPhase = 1'b1;
        if (lowDone) begin
          stateD           = ST_HIGH;
          strobes.clrPhase = 1'b1;
        end
      end
      ST_HIGH: begin
        strobes.incPhase = 1'b1;
        if (highDone) begin
          strobes.clrPhase = 1'b1;
          if (lastCycle) begin
            stateD           = ST_READY;
            strobes.clrTimer = 1'b1;
          end else begin
            stateD           = ST_LOW;
            strobes.incCycle = 1'b1;
          end
        end
      end
      ST_READY: begin
        if (activity) begin
          strobes.clrTimer = 1'b1;
        end else if (idleHit) begin
          stateD           = ST_LOW;
          strobes.clrPhase = 1'b1;
          strobes.clrCycle = 1'b1;
        end else begin
          strobes.incTimer = 1'b1;
        end
      end
      default: stateD = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_PAUSE;
      rasN   <= 1'b1;
      ready  <= 1'b0;
    end else begin
      stateQ <= stateD;
      rasN   <= (stateD != ST_LOW);
      ready  <= (stateD == ST_READY);
    end
  end

endmodule

// File: rtl/dramInitSeq.sv
module dramInitSeq
  import dramInitPkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int PAUSE_US      = 200,
  parameter int REFRESH_US    = 16000,
  parameter int INIT_CYCLES   = 8,
  parameter int RAS_LOW_CLKS  = 4,
  parameter int RAS_HIGH_CLKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic activity,
  output logic rasN,
  output logic casN,
  output logic ready
);

  // microsecond spans to clock counts, rounded up
  localparam longint unsigned PAUSE_L =
    (longint'(PAUSE_US) * CLK_FREQ_HZ + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned IDLE_L =
    (longint'(REFRESH_US) * CLK_FREQ_HZ + 64'd999_999) / 64'd1_000_000;
  localparam int PAUSE_CLKS = int'(PAUSE_L);
  localparam int IDLE_CLKS  = int'(IDLE_L);

  seqStrobes_t strobes;
  logic pauseDone, idleHit, lowDone, highDone, lastCycle;

  dramInitDatapath #(
    .PAUSE_CLKS   (PAUSE_CLKS),
    .IDLE_CLKS    (IDLE_CLKS),
    .INIT_CYCLES  (INIT_CYCLES),
    .RAS_LOW_CLKS (RAS_LOW_CLKS),
    .RAS_HIGH_CLKS(RAS_HIGH_CLKS)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pauseDone(pauseDone),
    .idleHit  (idleHit),
    .lowDone  (lowDone),
    .highDone (highDone),
    .lastCycle(lastCycle)
  );

  dramInitControl i_control (
    .clk      (clk),
    .rstN     (rstN),
    .activity (activity),
    .pauseDone(pauseDone),
    .idleHit  (idleHit),
    .lowDone  (lowDone),
    .highDone (highDone),
    .lastCycle(lastCycle),
    .strobes  (strobes),
    .rasN     (rasN),
    .ready    (ready)
  );

  // column strobe is never used by this sequencer
  assign casN = 1'b1;

endmodule

// File: rtl/dramInitSeqChecker.sv
module dramInitSeqChecker #(
  parameter int RAS_LOW_CLKS = 4
) (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic ready
);

  localparam int RUN_W = $clog2(RAS_LOW_CLKS + 2);

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       lowRun <= '0;
    else if (rasN)   lowRun <= '0;
    else if (lowRun != RUN_W'(RAS_LOW_CLKS + 1)) lowRun <= lowRun + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    (!rstN && $past(!rstN)) |-> (rasN && casN && !ready));

  // R6
  cas_inactive_chk: assert property (@(posedge clk) disable iff (!rstN)
    casN);

  // R9
  ready_ras_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !ready);

  // R4
  low_not_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (lowRun < RUN_W'(RAS_LOW_CLKS)));

  // R4
  low_full_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && !$past(rasN)) |-> (lowRun == RUN_W'(RAS_LOW_CLKS)));

  // R8
  reinit_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> !rasN);

endmodule

bind dramInitSeq dramInitSeqChecker #(
  .RAS_LOW_CLKS(RAS_LOW_CLKS)
) i_checker (
  .clk  (clk),
  .rstN (rstN),
  .rasN (rasN),
  .casN (casN),
  .ready(ready)
);

// File: tb/test_dramInitSeq.sv
module test_dramInitSeq;

  localparam longint unsigned HZ = 1_234_567;
  localparam int PUS = 200;
  localparam int RUS = 300;
  localparam int NCYC = 8;
  localparam int LOWC = 3;
  localparam int HIGHC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic activity = 1'b0;
  logic rasN, casN, ready;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  dramInitSeq #(
    .CLK_FREQ_HZ  (HZ),
    .PAUSE_US     (PUS),
    .REFRESH_US   (RUS),
    .INIT_CYCLES  (NCYC),
    .RAS_LOW_CLKS (LOWC),
    .RAS_HIGH_CLKS(HIGHC)
  ) i_dramInitSeq (
    .clk     (clk),
    .rstN    (rstN),
    .activity(activity),
    .rasN    (rasN),
    .casN    (casN),
    .ready   (ready)
  );

  function automatic longint ceilClks(longint us, longint hz);
    return (us * hz + 999_999) / 1_000_000;
  endfunction

  localparam longint EXP_P = (longint'(PUS) * HZ + 999_999) / 1_000_000;
  localparam longint EXP_I = (longint'(RUS) * HZ + 999_999) / 1_000_000;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // R2 R3: pause length with random activity noise
  task automatic measurePause(input string tag);
    longint cnt = 0;
    int bad = 0;
    while (rasN && cnt < 5000) begin
      activity = ($urandom % 3 == 0);
      step();
      cnt++;
      if (!casN || ready) bad++;
    end
    activity = 1'b0;
    check(cnt == ceilClks(PUS, HZ), {tag, " R2 first rasN low edge"}, cnt, ceilClks(PUS, HZ));
    check(bad == 0, {tag, " R6 casN high / ready low in pause"}, bad, 0);
  endtask

  // R4 R5 R3: train of init pulses, starting at a sample with rasN low
  task automatic measureInit(input string tag);
    int badLow = 0, badHigh = 0, badReady = 0;
    for (int i = 0; i < NCYC; i++) begin
      int lowW = 0;
      int highW = 0;
      while (!rasN && lowW < 100) begin
        if (ready) badReady++;
        activity = ($urandom % 2 == 0);
        step();
        lowW++;
      end
      while (rasN && !ready && highW < 100) begin
        activity = ($urandom % 2 == 0);
        step();
        highW++;
      end
      if (lowW != LOWC) badLow++;
      if (highW != HIGHC) badHigh++;
      if (i < NCYC - 1 && ready) badReady++;
    end
    activity = 1'b0;
    check(badLow == 0, {tag, " R4 low width"}, badLow, 0);
    check(badHigh == 0, {tag, " R4 precharge width"}, badHigh, 0);
    check(badReady == 0, {tag, " R5 ready low during train"}, badReady, 0);
    check(ready && rasN, {tag, " R5 ready after last pulse"}, ready, 1);
  endtask

  // R7: activity pulses at separation s (1..I edges) keep ready
  task automatic holdReady(input int sep, inout int bad);
    for (int k = 0; k < sep - 1; k++) begin
      step();
      if (!ready || !rasN || !casN) bad++;
    end
    activity = 1'b1;
    step();
    activity = 1'b0;
    if (!ready || !rasN || !casN) bad++;
  endtask

  // R8: count ready-high samples after the last activity edge
  task automatic measureIdle(input string tag);
    longint cnt = 0;
    while (ready && cnt < 100000) begin
      cnt++;
      step();
    end
    check(cnt == EXP_I, {tag, " R8 idle clocks until ready drops"}, cnt, EXP_I);
    check(!rasN, {tag, " R8 rasN low on the drop edge"}, rasN, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    int bad;
    void'($urandom(32'd5171));
    rstN = 1'b0;
    activity = 1'b0;
    repeat (4) step();
    // R1
    check(rasN && casN && !ready, "R1 reset outputs", {rasN, casN, ready}, 3'b110);
    check(EXP_P == 247 && EXP_I == 371, "R2 rounding of derived counts", EXP_P, 247);

    rstN = 1'b1;
    measurePause("power-up");
    measureInit("power-up");

    // R7: random separations, then exact boundary separation I
    bad = 0;
    for (int n = 0; n < 20; n++) holdReady($urandom_range(1, int'(EXP_I)), bad);
    for (int n = 0; n < 3; n++) holdReady(int'(EXP_I), bad);
    check(bad == 0, "R7 ready held with gaps up to I", bad, 0);

    measureIdle("first idle");
    measureInit("reinit");

    // R8 directly from entry into ready, no activity at all
    measureIdle("entry idle");
    measureInit("reinit2");

    // R1 R2: reset during a train restarts the pause
    measureIdle("pre-reset idle");
    step();
    step();
    rstN = 1'b0;
    repeat (3) step();
    check(rasN && casN && !ready, "R1 reset mid-train", {rasN, casN, ready}, 3'b110);
    rstN = 1'b1;
    measurePause("after reset");
    measureInit("after reset");

    bad = 0;
    for (int n = 0; n < 10; n++) holdReady($urandom_range(1, int'(EXP_I)), bad);
    check(bad == 0, "R7 ready held after reset", bad, 0);
    finishUp();
  end

endmodule